// File: doc/BRIEF.md
# LCD Timing Strobe Shaper

This block shapes the three timing strobes that drive an LCD panel. It runs in the pixel-clock domain, where a pixel-clock enable marks each pixel tick. An upstream counter supplies a one-tick line reference pulse, and a frame-start flag that is sampled together with it. The block uses these to produce three outputs:

- **Load strobe:** delayed from the line reference by a programmable 7-bit number of pixel ticks.
- **Line sync:** one pixel tick wide.
- **Frame sync:** its width is counted in whole line periods.

Each strobe has its own polarity bit. Two further outputs tell the pixel data path which pixel-clock edge presents data and whether data starts together with the load strobe or one pixel clock after it.

All configuration arrives on plain input ports. Every setting is captured at a line reference tick and then held until the next one. Because of this, a strobe that is already running never changes shape when software rewrites a field. Every output is registered, and every output is held when the pixel-clock enable is low.

Top module: `lcd_strobe_shaper`

## Requirements
- R1: With a delay field D of 1 to 127, the load strobe is active in exactly one pixel period: the one that begins at the D-th pixel tick after the reference tick. The reference tick is a clock edge with `line_ref` and `pix_en` both high.
- R2: With `cfg_late_data`=0 and D=0, the load strobe behaves exactly as if D=1. It never appears in the period right after the reference tick.
- R3: With `cfg_late_data`=1 and D=0, the load strobe is active in the pixel period that begins at the reference tick itself.
- R4: The load strobe is one pixel tick wide. A new reference that arrives while a delay is still counting restarts the count with the new delay, and the abandoned strobe is never emitted.
- R5: Each output equals its active state XOR its polarity bit. Polarity 0 means active high and polarity 1 means active low. This holds for `cfg_load_pol`, `cfg_line_pol` and `cfg_frame_pol`.
- R6: After reset and before the first reference tick, `load_o`=1, `line_sync_o`=0, `frame_sync_o`=0, `data_late_o`=0 and `clk_edge_sel_o`=0. These are the reset polarities: 1 for load and 0 for line and frame.
- R7: The line sync is active in the single pixel period that begins at each reference tick.
- R8: A reference tick with `frame_ref`=1 starts the frame sync, which then stays active for W line periods. W is 1, 2 or 3 for `cfg_frame_width` codes 0, 1 and 2. The reserved code 3 gives W=1. The frame sync ends at the W-th later reference tick.
- R9: Every configuration input is captured only at a reference tick. Changes between reference ticks do not alter any output, including a load strobe that is already pending, until the next reference tick.
- R10: While `pix_en` is low, no state advances and all outputs hold. A `line_ref` or `frame_ref` that is not accompanied by `pix_en` is ignored.
- R11: `data_late_o` and `clk_edge_sel_o` present the `cfg_late_data` and `cfg_clk_phase` values captured at the latest reference tick. For `clk_edge_sel_o`, 0 selects the rising edge and 1 the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel-clock enable; one tick per high cycle |
| line_ref | input | 1 | Internal line reference pulse |
| frame_ref | input | 1 | Frame-start flag, sampled with `line_ref` |
| cfg_load_dly | input | 7 | Load strobe delay in pixel ticks |
| cfg_late_data | input | 1 | Timing mode: 1 starts data one pixel clock after the load strobe |
| cfg_load_pol | input | 1 | Load strobe polarity (1 = active low) |
| cfg_line_pol | input | 1 | Line sync polarity (1 = active low) |
| cfg_frame_pol | input | 1 | Frame sync polarity (1 = active low) |
| cfg_frame_width | input | 2 | Frame sync width code in line periods |
| cfg_clk_phase | input | 1 | Data edge select (0 rising, 1 falling) |
| load_o | output | 1 | Delayed load strobe |
| line_sync_o | output | 1 | Line sync |
| frame_sync_o | output | 1 | Frame sync |
| data_late_o | output | 1 | Captured timing mode for the data path |
| clk_edge_sel_o | output | 1 | Captured pixel-clock edge select |

## Verification
The delay field is swept over all 128 values in both timing modes with a continuous pixel enable. This separates a correct count from off-by-one errors, and it separates the zero-delay rule of one mode from the other. Selected delays are repeated under a gapped pixel enable, which shows that the count advances on ticks and not on raw clocks.

A second reference is injected mid-count to expose duplicate or stale strobes. All four width codes are run against two line lengths, so that a width counted in clocks cannot pass for one counted in lines. A test that rewrites the configuration mid-line tells capture at the reference tick apart from continuous use of the inputs.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;

  // Per-line mode bits captured at every reference tick.
  typedef struct packed {
    logic load_pol;   // 1 = load strobe active low
    logic line_pol;   // 1 = line sync active low
    logic frame_pol;  // 1 = frame sync active low
    logic late_data;  // 1 = data one pixel clock after load
    logic clk_phase;  // 1 = data on falling pixel-clock edge
  } strobe_mode_t;

  localparam strobe_mode_t MODE_RESET = '{
    load_pol:  1'b1,
    line_pol:  1'b0,
    frame_pol: 1'b0,
    late_data: 1'b0,
    clk_phase: 1'b0
  };

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/lcd_mode_shadow.sv
module lcd_mode_shadow
  import lcd_strobe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  strobe_mode_t mode_in,
  output strobe_mode_t mode_eff
);

  strobe_mode_t mode_q;

  // The value used in the current tick: the fresh inputs on a reference
  // tick, otherwise the copy held since the last one.
  always_comb begin
    mode_eff = capture ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
    end else if (capture) begin
      mode_q <= mode_eff;
    end
  end

endmodule

// File: rtl/lcd_load_delay.sv
module lcd_load_delay #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  input  logic             late_mode,
  output logic             act_nxt,
  output logic             act_q
);

  localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;

  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;

  // Next state for one pixel tick; the register stage applies the enable.
  always_comb begin
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    act_nxt = 1'b0;
    if (start) begin
      if ((dly == CNT_ZERO) && late_mode) begin
        act_nxt = 1'b1;
        pend_n  = 1'b0;
      end else begin
        pend_n = 1'b1;
        cnt_n  = (dly == CNT_ZERO) ? CNT_ONE : dly;
      end
    end else if (pend_q) begin
      if (cnt_q == CNT_ONE) begin
        act_nxt = 1'b1;
        pend_n  = 1'b0;
      end else begin
        cnt_n = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_ZERO;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      act_q  <= act_nxt;
    end
  end

endmodule

// File: rtl/lcd_frame_span.sv
module lcd_frame_span #(
  parameter int FW_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line_start,
  input  logic            frame_start,
  input  logic [FW_W-1:0] width_code,
  output logic            act_nxt,
  output logic            act_q
);

  localparam logic [FW_W-1:0] REM_ONE   = FW_W'(1);
  localparam logic [FW_W-1:0] REM_ZERO  = '0;
  localparam logic [FW_W-1:0] CODE_RSVD = '1;

  logic [FW_W-1:0] rem_q, rem_n;
  logic [FW_W-1:0] span_lines;

  // Width in line periods; the top code is reserved and folds to one line.
  always_comb begin
    span_lines = (width_code == CODE_RSVD) ? REM_ONE : (width_code + REM_ONE);
  end

  always_comb begin
    rem_n   = rem_q;
    act_nxt = act_q;
    if (line_start) begin
      if (frame_start) begin
        act_nxt = 1'b1;
        rem_n   = span_lines;
      end else if (act_q) begin
        if (rem_q == REM_ONE) begin
          act_nxt = 1'b0;
          rem_n   = REM_ZERO;
        end else begin
          rem_n = rem_q - REM_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= REM_ZERO;
      act_q <= 1'b0;
    end else if (tick) begin
      rem_q <= rem_n;
      act_q <= act_nxt;
    end
  end

endmodule

// File: rtl/lcd_strobe_shaper.sv
module lcd_strobe_shaper
  import lcd_strobe_pkg::*;
#(
  parameter int DLY_W = 7,
  parameter int FW_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             line_ref,
  input  logic             frame_ref,
  input  logic [DLY_W-1:0] cfg_load_dly,
  input  logic             cfg_late_data,
  input  logic             cfg_load_pol,
  input  logic             cfg_line_pol,
  input  logic             cfg_frame_pol,
  input  logic [FW_W-1:0]  cfg_frame_width,
  input  logic             cfg_clk_phase,
  output logic             load_o,
  output logic             line_sync_o,
  output logic             frame_sync_o,
  output logic             data_late_o,
  output logic             clk_edge_sel_o
);

  logic         rst_sync_n;
  logic         ref_tick;
  strobe_mode_t mode_in;
  strobe_mode_t mode_eff;
  logic         load_nxt, load_act;
  logic         frame_nxt, frame_act;
  logic         line_act_q;
  logic         load_n, line_n, frame_n, late_n, edge_n;
  logic         load_q, line_q, frame_q, late_q, edge_q;

  lcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ref_tick = pix_en & line_ref;

  always_comb begin
    mode_in.load_pol  = cfg_load_pol;
    mode_in.line_pol  = cfg_line_pol;
    mode_in.frame_pol = cfg_frame_pol;
    mode_in.late_data = cfg_late_data;
    mode_in.clk_phase = cfg_clk_phase;
  end

  lcd_mode_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .capture  (ref_tick),
    .mode_in  (mode_in),
    .mode_eff (mode_eff)
  );

  lcd_load_delay #(.DLY_W(DLY_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (pix_en),
    .start     (line_ref),
    .dly       (cfg_load_dly),
    .late_mode (mode_eff.late_data),
    .act_nxt   (load_nxt),
    .act_q     (load_act)
  );

  lcd_frame_span #(.FW_W(FW_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (pix_en),
    .line_start  (line_ref),
    .frame_start (frame_ref),
    .width_code  (cfg_frame_width),
    .act_nxt     (frame_nxt),
    .act_q       (frame_act)
  );

  // Polarity applied ahead of the output flops so every pin is registered.
  always_comb begin
    load_n  = load_nxt  ^ mode_eff.load_pol;
    line_n  = line_ref  ^ mode_eff.line_pol;
    frame_n = frame_nxt ^ mode_eff.frame_pol;
    late_n  = mode_eff.late_data;
    edge_n  = mode_eff.clk_phase;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      line_act_q <= 1'b0;
      load_q     <= MODE_RESET.load_pol;
      line_q     <= MODE_RESET.line_pol;
      frame_q    <= MODE_RESET.frame_pol;
      late_q     <= MODE_RESET.late_data;
      edge_q     <= MODE_RESET.clk_phase;
    end else if (pix_en) begin
      line_act_q <= line_ref;
      load_q     <= load_n;
      line_q     <= line_n;
      frame_q    <= frame_n;
      late_q     <= late_n;
      edge_q     <= edge_n;
    end
  end

  assign load_o         = load_q;
  assign line_sync_o    = line_q;
  assign frame_sync_o   = frame_q;
  assign data_late_o    = late_q;
  assign clk_edge_sel_o = edge_q;

endmodule

// File: rtl/lcd_strobe_checker.sv
module lcd_strobe_checker #(
  parameter int DLY_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             line_ref,
  input logic             frame_ref,
  input logic             cfg_late_data,
  input logic [DLY_W-1:0] cfg_load_dly,
  input logic             load_act,
  input logic             line_act,
  input logic             frame_act,
  input logic             load_o,
  input logic             line_sync_o,
  input logic             frame_sync_o
);

  logic zero_dly;
  assign zero_dly = (cfg_load_dly == '0);

  p_zero_dly_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_ref && !cfg_late_data && zero_dly) |=> !load_act);

  p_zero_dly_mode1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_ref && cfg_late_data && zero_dly) |=> load_act);

  p_load_one_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && load_act && !(line_ref && cfg_late_data && zero_dly)) |=> !load_act);

  p_line_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_ref) |=> line_act);

  p_frame_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_ref && frame_ref) |=> frame_act);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(load_o) && $stable(line_sync_o) && $stable(frame_sync_o)));

endmodule

bind lcd_strobe_shaper lcd_strobe_checker #(.DLY_W(DLY_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .pix_en        (pix_en),
  .line_ref      (line_ref),
  .frame_ref     (frame_ref),
  .cfg_late_data (cfg_late_data),
  .cfg_load_dly  (cfg_load_dly),
  .load_act      (load_act),
  .line_act      (line_act_q),
  .frame_act     (frame_act),
  .load_o        (load_o),
  .line_sync_o   (line_sync_o),
  .frame_sync_o  (frame_sync_o)
);

// File: tb/tb_lcd_strobe_shaper.sv
module tb_lcd_strobe_shaper;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, line_ref, frame_ref;
  logic [6:0] cfg_load_dly;
  logic       cfg_late_data, cfg_load_pol, cfg_line_pol, cfg_frame_pol;
  logic [1:0] cfg_frame_width;
  logic       cfg_clk_phase;
  logic       load_o, line_sync_o, frame_sync_o, data_late_o, clk_edge_sel_o;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  lcd_strobe_shaper dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_ref(line_ref),
    .frame_ref(frame_ref), .cfg_load_dly(cfg_load_dly),
    .cfg_late_data(cfg_late_data), .cfg_load_pol(cfg_load_pol),
    .cfg_line_pol(cfg_line_pol), .cfg_frame_pol(cfg_frame_pol),
    .cfg_frame_width(cfg_frame_width), .cfg_clk_phase(cfg_clk_phase),
    .load_o(load_o), .line_sync_o(line_sync_o), .frame_sync_o(frame_sync_o),
    .data_late_o(data_late_o), .clk_edge_sel_o(clk_edge_sel_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One reference tick, then follow the load strobe until one tick past it.
  task automatic run_load(input int dly, input bit mode, input bit gap, input string req);
    int e   = (dly == 0 && !mode) ? 1 : dly;
    int nt  = 0;
    int bad = 0;
    int c   = 0;
    cfg_load_dly  = 7'(dly);
    cfg_late_data = mode;
    cfg_load_pol  = 1'b0;
    cfg_line_pol  = 1'b0;
    line_ref      = 1'b1;
    pix_en        = 1'b1;
    @(negedge clk);
    line_ref = 1'b0;
    while (nt <= e + 1) begin
      if (load_o !== (nt == e)) bad++;
      if (line_sync_o !== (nt == 0)) bad++;
      if (data_late_o !== mode) bad++;
      pix_en = gap ? ((c % 3) != 2) : 1'b1;
      @(negedge clk);
      if (pix_en) nt++;
      c++;
    end
    pix_en = 1'b1;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_frame(input int code, input int per, input bit pol, input string req);
    int w   = (code == 3) ? 1 : code + 1;
    int bad = 0;
    cfg_frame_width = 2'(code);
    cfg_frame_pol   = pol;
    pix_en          = 1'b1;
    for (int j = 0; j <= 4 * per + 1; j++) begin
      line_ref  = ((j % per) == 0);
      frame_ref = (j == 0);
      @(negedge clk);
      if (frame_sync_o !== ((j < w * per) ^ pol)) bad++;
    end
    line_ref  = 1'b0;
    frame_ref = 1'b0;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n = 1'b0;
    pix_en = 1'b0; line_ref = 1'b0; frame_ref = 1'b0;
    cfg_load_dly = 7'd0; cfg_late_data = 1'b0; cfg_load_pol = 1'b1;
    cfg_line_pol = 1'b0; cfg_frame_pol = 1'b0; cfg_frame_width = 2'd0;
    cfg_clk_phase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: reset levels
    chk(load_o === 1'b1, "R6 load", int'(load_o), 1);
    chk(line_sync_o === 1'b0, "R6 line", int'(line_sync_o), 0);
    chk(frame_sync_o === 1'b0, "R6 frame", int'(frame_sync_o), 0);
    chk(data_late_o === 1'b0 && clk_edge_sel_o === 1'b0, "R6 late/edge",
        int'({data_late_o, clk_edge_sel_o}), 0);

    // R10: references without the enable are ignored
    pix_en = 1'b0; line_ref = 1'b1; frame_ref = 1'b1; cfg_load_pol = 1'b0;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (line_sync_o !== 1'b0 || frame_sync_o !== 1'b0 || load_o !== 1'b1) bad++;
    end
    line_ref = 1'b0; frame_ref = 1'b0; pix_en = 1'b1;
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (line_sync_o !== 1'b0 || frame_sync_o !== 1'b0 || load_o !== 1'b1) bad++;
    end
    chk(bad == 0, "R10 gated reference ignored", bad, 0);

    // R1 R2: all delays, mode 0
    for (int d = 0; d < 128; d++) run_load(d, 1'b0, 1'b0, (d == 0) ? "R2 zero delay mode0" : "R1 delay mode0");
    // R1 R3: all delays, mode 1
    for (int d = 0; d < 128; d++) run_load(d, 1'b1, 1'b0, (d == 0) ? "R3 zero delay mode1" : "R1 delay mode1");
    // R10: gapped enable counts ticks, not clocks
    run_load(0, 1'b0, 1'b1, "R10 gapped d0 m0");
    run_load(0, 1'b1, 1'b1, "R10 gapped d0 m1");
    run_load(5, 1'b0, 1'b1, "R10 gapped d5");
    run_load(17, 1'b1, 1'b1, "R10 gapped d17");
    run_load(127, 1'b0, 1'b1, "R10 gapped d127");

    // R4: restart mid-count, only the second strobe appears
    cfg_late_data = 1'b0; cfg_load_pol = 1'b0; pix_en = 1'b1;
    bad = 0;
    for (int j = 0; j < 16; j++) begin
      line_ref     = (j == 0 || j == 5);
      cfg_load_dly = (j < 5) ? 7'd10 : 7'd3;
      @(negedge clk);
      if (load_o !== (j == 8)) bad++;
    end
    line_ref = 1'b0;
    chk(bad == 0, "R4 restart single strobe", bad, 0);

    // R8 R5: frame widths against two line lengths, and inverted polarity
    cfg_load_dly = 7'd2;
    for (int code = 0; code < 4; code++) run_frame(code, 5, 1'b0, (code == 3) ? "R8 reserved width" : "R8 frame width L5");
    for (int code = 0; code < 4; code++) run_frame(code, 3, 1'b0, "R8 frame width L3");
    run_frame(1, 4, 1'b1, "R5 frame polarity");
    cfg_frame_pol = 1'b0;

    // R9 R11 R5: settings captured at the reference tick only
    cfg_load_dly = 7'd4; cfg_late_data = 1'b0; cfg_load_pol = 1'b1;
    cfg_line_pol = 1'b0; cfg_clk_phase = 1'b0; cfg_frame_width = 2'd0;
    bad = 0;
    for (int j = 0; j < 8; j++) begin
      line_ref = (j == 0);
      if (j == 1) begin
        cfg_load_pol = 1'b0; cfg_line_pol = 1'b1; cfg_load_dly = 7'd1;
        cfg_late_data = 1'b1; cfg_clk_phase = 1'b1;
      end
      @(negedge clk);
      if (load_o !== !(j == 4)) bad++;
      if (line_sync_o !== (j == 0)) bad++;
      if (data_late_o !== 1'b0 || clk_edge_sel_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R9 mid-line change held off", bad, 0);
    line_ref = 1'b1;
    @(negedge clk);
    line_ref = 1'b0;
    chk(line_sync_o === 1'b0, "R5 line active low", int'(line_sync_o), 0);
    chk(data_late_o === 1'b1, "R11 late captured", int'(data_late_o), 1);
    chk(clk_edge_sel_o === 1'b1, "R11 edge captured", int'(clk_edge_sel_o), 1);
    @(negedge clk);
    chk(load_o === 1'b1, "R5 load active high after recapture", int'(load_o), 1);
    chk(line_sync_o === 1'b1, "R5 line idle high", int'(line_sync_o), 1);
    @(negedge clk);
    chk(load_o === 1'b0, "R4 load one tick wide", int'(load_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule